// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block holds the status flags that tell software why the controller last restarted or woke, and it decides where execution continues after each such event. Eight single-cycle event pulses feed it: power-on, brown-out, external master clear, software reset instruction, watchdog time-out, stack overflow, stack underflow and interrupt wake. Each event changes its own subset of the flags and leaves the others alone. The power mode at the time of the event also affects the result.

Along with the flags, the block produces a registered program-counter choice and a one-cycle load strobe. The choice is one of three: the reset address 0000h, resume at the next instruction (PC+2), or an interrupt vector. Software can set the power-on and brown-out flags back to their "nothing happened" value. It can also clear the two stack flags. When several events arrive together, a fixed priority picks the single event that acts. A software-controlled brown-out enable flag follows the brown-out configuration field.

Power modes on `pm_mode`: 00 full run, 01 power-managed run, 10 idle, 11 sleep. Idle and sleep are the two modes with bit 1 set.

Top module: `rst_cause_tracker`

## Requirements
- R1: A power-on pulse, or the asynchronous reset, leaves `rc_soft_n`, `rc_wdog_n` and `rc_pdown_n` at 1. It leaves `rc_pwr_n`, `rc_brown_n`, `rc_stk_full` and `rc_stk_empty` at 0. A power-on pulse also gives a load of `pc_sel`=0 (reset address) one cycle later. The asynchronous reset gives `pc_load`=0, `pc_sel`=0 and `pc_vec`=0.
- R2: A software reset instruction clears `rc_soft_n` and leaves every other flag unchanged. The next cycle carries a load with `pc_sel`=0.
- R3: A brown-out sets `rc_soft_n`, `rc_wdog_n` and `rc_pdown_n` to 1 and clears `rc_brown_n`. It leaves `rc_pwr_n` and both stack flags unchanged and loads `pc_sel`=0.
- R4: A master clear sets `rc_wdog_n` to 1 and loads `pc_sel`=0. In idle or sleep it also clears `rc_pdown_n`; in the two run modes it leaves `rc_pdown_n` unchanged. All other flags stay unchanged.
- R5: A watchdog time-out always clears `rc_wdog_n`. In the two run modes it leaves `rc_pdown_n` unchanged and loads `pc_sel`=0. In idle or sleep it clears `rc_pdown_n` and loads `pc_sel`=1 (resume at PC+2).
- R6: An interrupt wake in any mode other than full run clears `rc_pdown_n` and leaves the other flags unchanged. It loads `pc_sel`=2 with `pc_vec`=VEC_HI (default 0008h) when `irq_prio`=1 and `gie_hi`=1. It loads `pc_sel`=2 with `pc_vec`=VEC_LO (default 0018h) when `irq_prio`=0 and `gie_lo`=1. In every other case it loads `pc_sel`=1. In full run mode the pulse is ignored: no flag changes and no load.
- R7: A stack overflow sets `rc_stk_full` and a stack underflow sets `rc_stk_empty`, whatever the value of `stk_rst_en`. A load with `pc_sel`=0 follows only when `stk_rst_en`=1. Overflow outranks underflow.
- R8: `rc_sbo_en` is 1 exactly when `brn_cfg`=01 and is 0 for every other configuration. Events do not change it.
- R9: `sw_set_pwr` and `sw_set_brown` set `rc_pwr_n` and `rc_brown_n` to 1. `sw_clr_full` and `sw_clr_empty` clear the stack flags. If an event in the same cycle changes the same flag, the event wins. With no event and no strobe, all flags hold.
- R10: When several events pulse in one cycle, only the highest acts. The order, highest first, is power-on, brown-out, master clear, watchdog, stack overflow, stack underflow, software reset, interrupt wake.
- R11: `pc_load` is high for exactly one cycle, the cycle after an event that restarts or wakes execution, and `pc_sel`/`pc_vec` are valid with it. `pc_vec` is 0 unless `pc_sel`=2. Without such an event, `pc_load` is 0 and `pc_sel`/`pc_vec` hold. Flags change at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_por | input | 1 | Power-on event pulse |
| ev_bor | input | 1 | Brown-out event pulse |
| ev_mclr | input | 1 | External master clear pulse |
| ev_rstins | input | 1 | Software reset instruction pulse |
| ev_wdt | input | 1 | Watchdog time-out pulse |
| ev_stk_ovf | input | 1 | Stack overflow pulse |
| ev_stk_unf | input | 1 | Stack underflow pulse |
| ev_irq_wake | input | 1 | Interrupt wake pulse |
| pm_mode | input | 2 | Power mode: 00 run, 01 managed run, 10 idle, 11 sleep |
| stk_rst_en | input | 1 | Stack faults restart execution when 1 |
| gie_hi | input | 1 | High-priority global interrupt enable |
| gie_lo | input | 1 | Low-priority global interrupt enable |
| irq_prio | input | 1 | Waking interrupt is high priority when 1 |
| brn_cfg | input | 2 | Brown-out configuration field |
| sw_set_pwr | input | 1 | Software strobe: set power-on flag to 1 |
| sw_set_brown | input | 1 | Software strobe: set brown-out flag to 1 |
| sw_clr_full | input | 1 | Software strobe: clear overflow flag |
| sw_clr_empty | input | 1 | Software strobe: clear underflow flag |
| rc_soft_n | output | 1 | 0 after a software reset instruction |
| rc_wdog_n | output | 1 | 0 after a watchdog time-out |
| rc_pdown_n | output | 1 | 0 after an event met in a low-power mode |
| rc_pwr_n | output | 1 | 0 after power-on until software sets it |
| rc_brown_n | output | 1 | 0 after brown-out until software sets it |
| rc_stk_full | output | 1 | Stack overflow seen |
| rc_stk_empty | output | 1 | Stack underflow seen |
| rc_sbo_en | output | 1 | Software brown-out enable |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_sel | output | 2 | 0 reset address, 1 PC+2, 2 vector |
| pc_vec | output | ADDR_W | Target address for `pc_sel`=0 or 2 |

## Verification
The flag bits are pure state with no path back to normal operation. A wrong bit therefore shows up one cycle after the event that wrote it and stays wrong until another event or software strobe overwrites that bit. A wrong winner in the priority pick or a wrong mode decode appears one cycle later as a wrong `pc_sel`, a missing or extra `pc_load`, or a flag change in the wrong subset. Comparing every output on every cycle against an independent model exposes each of these at the first cycle they differ.

// File: rtl/rcst_pkg.sv
package rcst_pkg;
  localparam int NUM_EV = 8;
  localparam int EV_W   = $clog2(NUM_EV);

  // index equals priority, 0 highest
  typedef enum logic [EV_W-1:0] {
    EV_POR  = 3'd0,
    EV_BOR  = 3'd1,
    EV_MCLR = 3'd2,
    EV_WDT  = 3'd3,
    EV_OVF  = 3'd4,
    EV_UNF  = 3'd5,
    EV_RSTI = 3'd6,
    EV_IRQ  = 3'd7
  } ev_e;

  localparam logic [1:0] PC_ZERO = 2'd0;
  localparam logic [1:0] PC_NEXT = 2'd1;
  localparam logic [1:0] PC_VEC  = 2'd2;

  typedef struct packed {
    logic soft_n;
    logic wdog_n;
    logic pdown_n;
    logic pwr_n;
    logic brown_n;
    logic stk_full;
    logic stk_empty;
  } flags_t;

  localparam flags_t FLAGS_COLD = '{soft_n: 1'b1, wdog_n: 1'b1, pdown_n: 1'b1,
                                    pwr_n: 1'b0, brown_n: 1'b0,
                                    stk_full: 1'b0, stk_empty: 1'b0};
endpackage

// File: rtl/rcst_rsync.sv
module rcst_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/rcst_arb.sv
module rcst_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rcst_flags.sv
module rcst_flags
  import rcst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_vld,
  input  ev_e        ev_sel,
  input  logic       low_pwr,
  input  logic       sw_set_pwr,
  input  logic       sw_set_brown,
  input  logic       sw_clr_full,
  input  logic       sw_clr_empty,
  output flags_t     flags_q
);
  flags_t flags_d;
  logic   flags_en;

  assign flags_en = ev_vld | sw_set_pwr | sw_set_brown | sw_clr_full | sw_clr_empty;

  always_comb begin
    flags_d = flags_q;
    if (sw_set_pwr)   flags_d.pwr_n     = 1'b1;
    if (sw_set_brown) flags_d.brown_n   = 1'b1;
    if (sw_clr_full)  flags_d.stk_full  = 1'b0;
    if (sw_clr_empty) flags_d.stk_empty = 1'b0;
    if (ev_vld) begin
      unique case (ev_sel)
        EV_POR:  flags_d = FLAGS_COLD;
        EV_BOR: begin
          flags_d.soft_n  = 1'b1;
          flags_d.wdog_n  = 1'b1;
          flags_d.pdown_n = 1'b1;
          flags_d.brown_n = 1'b0;
        end
        EV_MCLR: begin
          flags_d.wdog_n = 1'b1;
          if (low_pwr) flags_d.pdown_n = 1'b0;
        end
        EV_WDT: begin
          flags_d.wdog_n = 1'b0;
          if (low_pwr) flags_d.pdown_n = 1'b0;
        end
        EV_OVF:  flags_d.stk_full  = 1'b1;
        EV_UNF:  flags_d.stk_empty = 1'b1;
        EV_RSTI: flags_d.soft_n    = 1'b0;
        EV_IRQ:  flags_d.pdown_n   = 1'b0;
        default: flags_d = flags_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_COLD;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/rcst_pcsel.sv
module rcst_pcsel
  import rcst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_HI = 'h0008,
  parameter logic [ADDR_W-1:0] VEC_LO = 'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_vld,
  input  ev_e               ev_sel,
  input  logic              low_pwr,
  input  logic              stk_rst_en,
  input  logic              gie_hi,
  input  logic              gie_lo,
  input  logic              irq_prio,
  output logic              load_q,
  output logic [1:0]        sel_q,
  output logic [ADDR_W-1:0] vec_q
);
  logic              load_d;
  logic [1:0]        sel_d;
  logic [ADDR_W-1:0] vec_d;

  always_comb begin
    load_d = 1'b0;
    sel_d  = PC_ZERO;
    vec_d  = '0;
    if (ev_vld) begin
      unique case (ev_sel)
        EV_WDT: begin
          load_d = 1'b1;
          sel_d  = low_pwr ? PC_NEXT : PC_ZERO;
        end
        EV_OVF, EV_UNF: load_d = stk_rst_en;
        EV_IRQ: begin
          load_d = 1'b1;
          if (irq_prio && gie_hi) begin
            sel_d = PC_VEC;
            vec_d = VEC_HI;
          end else if (!irq_prio && gie_lo) begin
            sel_d = PC_VEC;
            vec_d = VEC_LO;
          end else begin
            sel_d = PC_NEXT;
          end
        end
        default: load_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
    end else begin
      load_q <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= PC_ZERO;
      vec_q <= '0;
    end else if (load_d) begin
      sel_q <= sel_d;
      vec_q <= vec_d;
    end
  end
endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rcst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_HI = 'h0008,
  parameter logic [ADDR_W-1:0] VEC_LO = 'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_por,
  input  logic              ev_bor,
  input  logic              ev_mclr,
  input  logic              ev_rstins,
  input  logic              ev_wdt,
  input  logic              ev_stk_ovf,
  input  logic              ev_stk_unf,
  input  logic              ev_irq_wake,
  input  logic [1:0]        pm_mode,
  input  logic              stk_rst_en,
  input  logic              gie_hi,
  input  logic              gie_lo,
  input  logic              irq_prio,
  input  logic [1:0]        brn_cfg,
  input  logic              sw_set_pwr,
  input  logic              sw_set_brown,
  input  logic              sw_clr_full,
  input  logic              sw_clr_empty,
  output logic              rc_soft_n,
  output logic              rc_wdog_n,
  output logic              rc_pdown_n,
  output logic              rc_pwr_n,
  output logic              rc_brown_n,
  output logic              rc_stk_full,
  output logic              rc_stk_empty,
  output logic              rc_sbo_en,
  output logic              pc_load,
  output logic [1:0]        pc_sel,
  output logic [ADDR_W-1:0] pc_vec
);
  logic              rst_sync_n;
  logic [NUM_EV-1:0] ev_req;
  logic              ev_vld;
  logic [EV_W-1:0]   ev_idx;
  ev_e               ev_sel;
  logic              low_pwr;
  logic              irq_ok;
  flags_t            flags_q;

  assign low_pwr = pm_mode[1];
  assign irq_ok  = ev_irq_wake & (pm_mode != 2'b00);

  assign ev_req = {irq_ok, ev_rstins, ev_stk_unf, ev_stk_ovf,
                   ev_wdt, ev_mclr, ev_bor, ev_por};

  rcst_rsync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rcst_arb #(.N(NUM_EV)) u_arb (
    .req (ev_req),
    .vld (ev_vld),
    .idx (ev_idx)
  );

  assign ev_sel = ev_e'(ev_idx);

  rcst_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ev_vld       (ev_vld),
    .ev_sel       (ev_sel),
    .low_pwr      (low_pwr),
    .sw_set_pwr   (sw_set_pwr),
    .sw_set_brown (sw_set_brown),
    .sw_clr_full  (sw_clr_full),
    .sw_clr_empty (sw_clr_empty),
    .flags_q      (flags_q)
  );

  rcst_pcsel #(.ADDR_W(ADDR_W), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_pc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_vld     (ev_vld),
    .ev_sel     (ev_sel),
    .low_pwr    (low_pwr),
    .stk_rst_en (stk_rst_en),
    .gie_hi     (gie_hi),
    .gie_lo     (gie_lo),
    .irq_prio   (irq_prio),
    .load_q     (pc_load),
    .sel_q      (pc_sel),
    .vec_q      (pc_vec)
  );

  assign rc_soft_n    = flags_q.soft_n;
  assign rc_wdog_n    = flags_q.wdog_n;
  assign rc_pdown_n   = flags_q.pdown_n;
  assign rc_pwr_n     = flags_q.pwr_n;
  assign rc_brown_n   = flags_q.brown_n;
  assign rc_stk_full  = flags_q.stk_full;
  assign rc_stk_empty = flags_q.stk_empty;
  assign rc_sbo_en    = (brn_cfg == 2'b01);
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              ev_por,
  input logic              ev_bor,
  input logic              ev_mclr,
  input logic              ev_rstins,
  input logic              ev_wdt,
  input logic              ev_stk_ovf,
  input logic              ev_stk_unf,
  input logic              ev_irq_wake,
  input logic [1:0]        pm_mode,
  input logic              stk_rst_en,
  input logic              sw_set_pwr,
  input logic              sw_set_brown,
  input logic              sw_clr_full,
  input logic              sw_clr_empty,
  input logic              rc_soft_n,
  input logic              rc_wdog_n,
  input logic              rc_pdown_n,
  input logic              rc_pwr_n,
  input logic              rc_brown_n,
  input logic              rc_stk_full,
  input logic              rc_stk_empty,
  input logic              pc_load,
  input logic [1:0]        pc_sel,
  input logic [ADDR_W-1:0] pc_vec
);
  logic above_wdt;
  logic above_stk;
  logic any_ev;
  logic any_sw;

  assign above_wdt = ev_por | ev_bor | ev_mclr;
  assign above_stk = above_wdt | ev_wdt;
  assign any_ev    = ev_por | ev_bor | ev_mclr | ev_rstins | ev_wdt |
                     ev_stk_ovf | ev_stk_unf | ev_irq_wake;
  assign any_sw    = sw_set_pwr | sw_set_brown | sw_clr_full | sw_clr_empty;

  AST_POR_COLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_por |=> rc_soft_n && rc_wdog_n && rc_pdown_n && !rc_pwr_n && !rc_brown_n &&
               !rc_stk_full && !rc_stk_empty && pc_load && pc_sel == 2'd0); // R1

  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_rstins && !above_stk && !ev_stk_ovf && !ev_stk_unf)
      |=> !rc_soft_n && pc_load && pc_sel == 2'd0); // R2

  AST_BROWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_bor && !ev_por) |=> !rc_brown_n && rc_soft_n && rc_pdown_n && pc_load); // R3

  AST_MCLR_LOWPWR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_mclr && !ev_por && !ev_bor && pm_mode[1]) |=> !rc_pdown_n && rc_wdog_n); // R4

  AST_WDT_WAKE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_wdt && !above_wdt && pm_mode[1])
      |=> !rc_wdog_n && !rc_pdown_n && pc_load && pc_sel == 2'd1); // R5

  AST_IRQ_RUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_irq_wake && pm_mode == 2'b00 && !any_sw &&
     !(ev_por | ev_bor | ev_mclr | ev_rstins | ev_wdt | ev_stk_ovf | ev_stk_unf))
      |=> !pc_load && $stable(rc_pdown_n) && $stable(rc_wdog_n) && $stable(rc_soft_n)); // R6

  AST_STK_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_stk_ovf && !above_stk && !stk_rst_en) |=> rc_stk_full && !pc_load); // R7

  AST_PRIO_POR_OVER_SOFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_por && ev_rstins) |=> rc_soft_n); // R10

  AST_NO_EVENT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_ev |=> !pc_load && $stable(pc_sel) && $stable(pc_vec)); // R11

  AST_VEC_ZERO_UNLESS_VECTOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_sel != 2'd2) |-> (pc_vec == '0)); // R11
endmodule

bind rst_cause_tracker rst_cause_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_rst_cause_tracker.sv
module sim_rst_cause_tracker;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic ev_por, ev_bor, ev_mclr, ev_rstins, ev_wdt, ev_stk_ovf, ev_stk_unf, ev_irq_wake;
  logic [1:0] pm_mode, brn_cfg;
  logic stk_rst_en, gie_hi, gie_lo, irq_prio;
  logic sw_set_pwr, sw_set_brown, sw_clr_full, sw_clr_empty;
  logic rc_soft_n, rc_wdog_n, rc_pdown_n, rc_pwr_n, rc_brown_n, rc_stk_full, rc_stk_empty, rc_sbo_en;
  logic pc_load;
  logic [1:0] pc_sel;
  logic [AW-1:0] pc_vec;

  rst_cause_tracker u0 (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  logic [6:0] m_flags;   // soft,wdog,pdown,pwr,brown,full,empty
  logic m_load;
  logic [1:0] m_sel;
  logic [AW-1:0] m_vec;
  string tag = "R1";

  always @(posedge clk) begin
    int n;
    logic s, w, p, pw, b, f, e;
    logic irq_live;
    {s, w, p, pw, b, f, e} = m_flags;
    irq_live = ev_irq_wake && pm_mode != 2'b00;
    n = ev_por + ev_bor + ev_mclr + ev_rstins + ev_wdt + ev_stk_ovf + ev_stk_unf + irq_live;
    if (!rst_n) begin
      m_flags = 7'b1110000; m_load = 0; m_sel = 0; m_vec = 0; tag = "R1";
    end else begin
      if (sw_set_pwr) pw = 1;
      if (sw_set_brown) b = 1;
      if (sw_clr_full) f = 0;
      if (sw_clr_empty) e = 0;
      m_load = 0;
      tag = "R9";
      if (ev_por) begin
        {s, w, p, pw, b, f, e} = 7'b1110000; m_load = 1; m_sel = 0; m_vec = 0; tag = "R1";
      end else if (ev_bor) begin
        s = 1; w = 1; p = 1; b = 0; m_load = 1; m_sel = 0; m_vec = 0; tag = "R3";
      end else if (ev_mclr) begin
        w = 1; if (pm_mode >= 2) p = 0; m_load = 1; m_sel = 0; m_vec = 0; tag = "R4";
      end else if (ev_wdt) begin
        w = 0; m_load = 1; m_vec = 0; tag = "R5";
        if (pm_mode >= 2) begin p = 0; m_sel = 1; end else m_sel = 0;
      end else if (ev_stk_ovf) begin
        f = 1; tag = "R7";
        if (stk_rst_en) begin m_load = 1; m_sel = 0; m_vec = 0; end
      end else if (ev_stk_unf) begin
        e = 1; tag = "R7";
        if (stk_rst_en) begin m_load = 1; m_sel = 0; m_vec = 0; end
      end else if (ev_rstins) begin
        s = 0; m_load = 1; m_sel = 0; m_vec = 0; tag = "R2";
      end else if (ev_irq_wake) begin
        tag = "R6";
        if (pm_mode != 2'b00) begin
          p = 0; m_load = 1;
          if (irq_prio && gie_hi) begin m_sel = 2; m_vec = 16'h0008; end
          else if (!irq_prio && gie_lo) begin m_sel = 2; m_vec = 16'h0018; end
          else begin m_sel = 1; m_vec = 0; end
        end
      end
      if (n > 1) tag = "R10";
      m_flags = {s, w, p, pw, b, f, e};
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      summary();
    end
  end

  task automatic compare();
    logic [6:0] act;
    act = {rc_soft_n, rc_wdog_n, rc_pdown_n, rc_pwr_n, rc_brown_n, rc_stk_full, rc_stk_empty};
    checks++;
    if (act !== m_flags) begin
      errors++;
      $display("FAIL %s flags: actual %b expected %b", tag, act, m_flags);
    end
    checks++;
    if (pc_load !== m_load || pc_sel !== m_sel || pc_vec !== m_vec) begin
      errors++;
      $display("FAIL R11 pc (%s): actual load %b sel %0d vec %h expected load %b sel %0d vec %h",
               tag, pc_load, pc_sel, pc_vec, m_load, m_sel, m_vec);
    end
    checks++;
    if (rc_sbo_en !== (brn_cfg == 2'b01)) begin
      errors++;
      $display("FAIL R8 sbo_en: actual %b expected %b", rc_sbo_en, brn_cfg == 2'b01);
    end
  endtask

  task automatic idle_inputs();
    {ev_por, ev_bor, ev_mclr, ev_rstins, ev_wdt, ev_stk_ovf, ev_stk_unf, ev_irq_wake} = '0;
    {sw_set_pwr, sw_set_brown, sw_clr_full, sw_clr_empty} = '0;
  endtask

  // one cycle: drive at falling edge, check just after the rising edge
  task automatic step(input logic [7:0] ev, input logic [3:0] sw);
    @(negedge clk);
    {ev_irq_wake, ev_rstins, ev_stk_unf, ev_stk_ovf, ev_wdt, ev_mclr, ev_bor, ev_por} = ev;
    {sw_clr_empty, sw_clr_full, sw_set_brown, sw_set_pwr} = sw;
    @(posedge clk);
    #1 compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (3) step(8'h00, 4'h0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) step(8'h00, 4'h0);
  endtask

  initial begin
    idle_inputs();
    pm_mode = 0; brn_cfg = 2'b01; stk_rst_en = 1; gie_hi = 0; gie_lo = 0; irq_prio = 0;
    rst_n = 0;
    do_reset();
    // directed: each event in several modes
    step(8'h02, 4'h3);                 // R3 brown-out, then software set
    step(8'h00, 4'h3);                 // R9 software set pwr/brown
    step(8'h40, 4'h0);                 // R2 soft reset
    pm_mode = 2'b11;
    step(8'h04, 4'h0);                 // R4 master clear in sleep
    pm_mode = 2'b01;
    step(8'h04, 4'h0);                 // R4 master clear in managed run
    step(8'h08, 4'h0);                 // R5 watchdog, run
    pm_mode = 2'b10;
    step(8'h08, 4'h0);                 // R5 watchdog wake
    irq_prio = 1; gie_hi = 1;
    step(8'h80, 4'h0);                 // R6 high vector
    irq_prio = 0; gie_lo = 1;
    step(8'h80, 4'h0);                 // R6 low vector
    gie_lo = 0;
    step(8'h80, 4'h0);                 // R6 PC+2
    pm_mode = 2'b00;
    step(8'h80, 4'h0);                 // R6 ignored in run
    stk_rst_en = 0;
    step(8'h10, 4'h0);                 // R7 overflow, no restart
    step(8'h20, 4'h0);                 // R7 underflow, no restart
    step(8'h00, 4'hC);                 // R9 clear stack flags
    stk_rst_en = 1;
    step(8'h30, 4'h4);                 // R7 overflow wins over underflow and strobe
    step(8'h41, 4'h0);                 // R10 power-on over soft reset
    step(8'hFE, 4'h0);                 // R10 brown-out wins
    brn_cfg = 2'b10;
    step(8'h00, 4'h0);                 // R8
    step(8'h01, 4'h0);                 // R1 power-on pulse
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ev;
      logic [3:0] sw;
      ev = '0;
      if ($urandom_range(0, 2) == 0) begin
        for (int k = 1; k < 8; k++) ev[k] = ($urandom_range(0, 5) == 0);
        ev[0] = ($urandom_range(0, 39) == 0);
      end
      sw = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      pm_mode = 2'($urandom); stk_rst_en = 1'($urandom);
      gie_hi = 1'($urandom); gie_lo = 1'($urandom); irq_prio = 1'($urandom);
      if ($urandom_range(0, 15) == 0) brn_cfg = 2'($urandom);
      step(ev, sw);
      if (i == 2000) do_reset();
    end
    summary();
  end
endmodule